// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block times an integrating analog-to-digital converter of the dual-slope kind. It cycles through four phases: auto-zero, signal integration, reference de-integration and a trailing zero-integration. It drives one enable strobe per phase to the analog switch network. A 2-bit rate code picks one of four conversion rates, and each rate scales all four phase durations by the same factor. Across the cycle the phases keep the split 20% / 20% / 44% / 16%.

During de-integration an external comparator signals, with a rising edge, that the integrator output has crossed zero. The sequencer records how many de-integration clocks had elapsed at the first such edge and commits that count as the conversion result. If no edge arrives, it commits the full de-integration length and raises an overrange flag. A one-cycle end-of-conversion pulse marks the last clock of zero-integration. From that pulse the result and the flag are valid.

A parameter gives the number of clocks per millisecond (4000 for a 4 MHz clock). A test setup can lower it to shorten every phase without changing the proportions.

Top module: `dslope_sequencer`

## Requirements
- R1: Exactly one of the four phase enables is high at every clock, and the auto-zero enable is the one high during and right after reset.
- R2: Phases follow the fixed cycle auto-zero, integrate, de-integrate, zero-integrate, then auto-zero again.
- R3: Phase durations in milliseconds depend on the latched rate code. Code 2'b00 gives auto-zero 20, integrate 20, de-integrate 44, zero-integrate 16. Code 2'b01 gives 10, 10, 22, 8. Code 2'b10 gives 40, 40, 88, 32. Code 2'b11 gives 100, 100, 220, 80. Each millisecond lasts CLKS_PER_MS clocks.
- R4: The rate code is latched only at the clock edge that ends zero-integration, which is the start of auto-zero. A change of the rate input at any other time has no effect on the running conversion.
- R5: The comparator input is sampled once per clock. On the first clock of de-integration at which it is sampled high after being low on the previous clock, the result becomes the number of de-integration clocks completed before that clock. That number is 0 on the first de-integration clock and the de-integration length minus 1 on its last.
- R6: Only the first rising edge within a de-integration phase counts. Later edges in the same phase are ignored. A rising edge outside de-integration is ignored, so an input already high when de-integration begins gives no capture.
- R7: If no rising edge is seen during de-integration, the result is the full de-integration length in clocks and the overrange flag is 1. Otherwise the flag is 0.
- R8: The result and the flag are updated only at the edge that ends de-integration, and they hold until the next such edge. The end-of-conversion output is high for exactly the last clock of zero-integration and low on the following clock.
- R9: An active-low asynchronous reset forces auto-zero, restarts the phase timer, and clears the result, the flag and the latched rate code (back to 2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rate_sel | input | 2 | Conversion rate code, latched at auto-zero start |
| zc | input | 1 | Comparator zero-crossing indication |
| az_en | output | 1 | Auto-zero phase enable |
| int_en | output | 1 | Signal integration phase enable |
| dint_en | output | 1 | Reference de-integration phase enable |
| zi_en | output | 1 | Zero-integration phase enable |
| eoc | output | 1 | End-of-conversion pulse, last zero-integration clock |
| result | output | CNT_W | Committed de-integration count |
| ovr | output | 1 | Overrange flag, no crossing seen |

## Verification
Two functions can meet on one clock: capturing a comparator edge and committing the result at the end of de-integration. The stimulus table provokes this by raising the comparator input exactly on the last de-integration clock, at two different rates. The outcome is judged correct when the committed count equals the length minus one and the overrange flag stays low, not the full-scale value with the flag set. A crossing on the first de-integration clock covers the opposite boundary, where the expected count is zero.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Enum order is the phase cycle order; the sequencer steps through it.
  typedef enum logic [1:0] {
    PH_AZ   = 2'd0,
    PH_INT  = 2'd1,
    PH_DINT = 2'd2,
    PH_ZI   = 2'd3
  } phase_e;

  // Durations at the fastest rate (code 2'b01), in milliseconds.
  localparam int unsigned BASE_AZ_MS   = 10;
  localparam int unsigned BASE_INT_MS  = 10;
  localparam int unsigned BASE_DINT_MS = 22;
  localparam int unsigned BASE_ZI_MS   = 8;
  localparam int unsigned MAX_MULT     = 10;
  localparam int unsigned MAX_PHASE_MS = BASE_DINT_MS * MAX_MULT;

  function automatic int unsigned rate_mult(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 1;
      2'b10:   return 4;
      default: return MAX_MULT;
    endcase
  endfunction

  function automatic int unsigned phase_ms(input phase_e ph, input logic [1:0] code);
    int unsigned base;
    case (ph)
      PH_AZ:   base = BASE_AZ_MS;
      PH_INT:  base = BASE_INT_MS;
      PH_DINT: base = BASE_DINT_MS;
      default: base = BASE_ZI_MS;
    endcase
    return base * rate_mult(code);
  endfunction

endpackage

// File: rtl/dss_timer.sv
module dss_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_nxt;

  assign last = (cnt == len - 1'b1);

  always_comb begin
    if (last) cnt_nxt = '0;
    else      cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/dss_phase_fsm.sv
module dss_phase_fsm
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last,
  input  logic [1:0] rate_sel,
  output phase_e     phase,
  output logic [1:0] rate_q
);

  phase_e     phase_nxt;
  logic       rate_load;

  always_comb begin
    phase_nxt = phase;
    if (last) begin
      case (phase)
        PH_AZ:   phase_nxt = PH_INT;
        PH_INT:  phase_nxt = PH_DINT;
        PH_DINT: phase_nxt = PH_ZI;
        default: phase_nxt = PH_AZ;
      endcase
    end
  end

  assign rate_load = last && (phase == PH_ZI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_AZ;
    else        phase <= phase_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_q <= 2'b00;
    else if (rate_load) rate_q <= rate_sel;
  end

endmodule

// File: rtl/dss_capture.sv
module dss_capture #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic             in_dint,
  input  logic             dint_start,
  input  logic             dint_last,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] result,
  output logic             ovr
);

  logic             zc_q;
  logic             rise;
  logic             hit;
  logic             hit_set;
  logic [CNT_W-1:0] hit_val;
  logic             commit;
  logic [CNT_W-1:0] result_nxt;
  logic             ovr_nxt;

  assign rise    = zc && !zc_q;
  assign hit_set = in_dint && rise && !hit;
  assign commit  = in_dint && dint_last;

  always_comb begin
    if (hit)       result_nxt = hit_val;
    else if (rise) result_nxt = cnt;
    else           result_nxt = len;
    ovr_nxt = !hit && !rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_q <= 1'b0;
    else        zc_q <= zc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hit <= 1'b0;
    else if (dint_start) hit <= 1'b0;
    else if (hit_set)    hit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_val <= '0;
    else if (hit_set) hit_val <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      ovr    <= 1'b0;
    end else if (commit) begin
      result <= result_nxt;
      ovr    <= ovr_nxt;
    end
  end

endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
  import dss_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 4000,
  localparam int unsigned MAX_CLKS   = MAX_PHASE_MS * CLKS_PER_MS,
  localparam int unsigned CNT_W      = $clog2(MAX_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_sel,
  input  logic             zc,
  output logic             az_en,
  output logic             int_en,
  output logic             dint_en,
  output logic             zi_en,
  output logic             eoc,
  output logic [CNT_W-1:0] result,
  output logic             ovr
);

  phase_e           phase;
  logic [1:0]       rate_q;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic             last;

  always_comb begin
    len = CNT_W'(phase_ms(phase, rate_q) * CLKS_PER_MS);
  end

  dss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .len   (len),
    .cnt   (cnt),
    .last  (last)
  );

  dss_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .last     (last),
    .rate_sel (rate_sel),
    .phase    (phase),
    .rate_q   (rate_q)
  );

  dss_capture #(.CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .zc         (zc),
    .in_dint    (phase == PH_DINT),
    .dint_start (last && (phase == PH_INT)),
    .dint_last  (last),
    .cnt        (cnt),
    .len        (len),
    .result     (result),
    .ovr        (ovr)
  );

  assign az_en   = (phase == PH_AZ);
  assign int_en  = (phase == PH_INT);
  assign dint_en = (phase == PH_DINT);
  assign zi_en   = (phase == PH_ZI);
  assign eoc     = zi_en && last;

endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         az_en,
  input logic         int_en,
  input logic         dint_en,
  input logic         zi_en,
  input logic         eoc,
  input logic [W-1:0] result,
  input logic         ovr
);

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({az_en, int_en, dint_en, zi_en}) == 1);

  assert_az_to_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(az_en) |-> int_en);

  assert_int_to_dint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> dint_en);

  assert_dint_to_zi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dint_en) |-> zi_en);

  assert_zi_to_az_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zi_en) |-> az_en);

  assert_eoc_in_zi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> zi_en);

  assert_eoc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (!eoc && az_en));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(dint_en) |-> ($stable(result) && $stable(ovr)));

endmodule

bind dslope_sequencer dslope_sequencer_chk #(.W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .az_en   (az_en),
  .int_en  (int_en),
  .dint_en (dint_en),
  .zi_en   (zi_en),
  .eoc     (eoc),
  .result  (result),
  .ovr     (ovr)
);

// File: tb/dslope_sequencer_test.sv
module dslope_sequencer_test;

  localparam int unsigned CPM   = 2;
  localparam int unsigned CNT_W = $clog2(220 * CPM + 1);
  localparam int unsigned NVEC  = 6;

  // Vector: {exp_ovr, exp_result[11:0], crossing offset[9:0] (1023 = none), rate[1:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 12'd10,  10'd10,   2'b00},
    {1'b0, 12'd0,   10'd0,    2'b01},
    {1'b0, 12'd175, 10'd175,  2'b10},
    {1'b1, 12'd440, 10'd1023, 2'b11},
    {1'b0, 12'd87,  10'd87,   2'b00},
    {1'b1, 12'd44,  10'd1023, 2'b01}
  };

  logic             clk;
  logic             rst_n;
  logic [1:0]       rate_sel;
  logic             zc;
  logic             az_en, int_en, dint_en, zi_en, eoc, ovr;
  logic [CNT_W-1:0] result;

  int checks = 0;
  int fails  = 0;
  int onehot_err = 0;

  dslope_sequencer #(.CLKS_PER_MS(CPM)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .zc(zc),
    .az_en(az_en), .int_en(int_en), .dint_en(dint_en), .zi_en(zi_en),
    .eoc(eoc), .result(result), .ovr(ovr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk)
    if (rst_n === 1'b1 && $countones({az_en, int_en, dint_en, zi_en}) != 1)
      onehot_err++;

  // Phase lengths in clocks from the millisecond table of R3.
  function automatic int exp_clks(input logic [1:0] r, input int ph);
    int ms[4];
    case (r)
      2'b00:   ms = '{20, 20, 44, 16};
      2'b01:   ms = '{10, 10, 22, 8};
      2'b10:   ms = '{40, 40, 88, 32};
      default: ms = '{100, 100, 220, 80};
    endcase
    return ms[ph] * CPM;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Entry: at a negedge in the first auto-zero clock. mode 0 single pulse at
  // off, mode 1 input high from integrate start, mode 2 pulses at off and off2.
  task automatic run_conv(input logic [1:0] r, input logic [1:0] nxt, input int mode,
                          input int off, input int off2, input int exp_res,
                          input bit exp_ovr, input string tag);
    int n;
    n = 0;
    while (az_en && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp_clks(r, 0), {tag, " R3 auto-zero length"}, n, exp_clks(r, 0));
    rate_sel = r ^ 2'b11;  // R4: change mid-conversion must be ignored
    if (mode == 1) zc = 1'b1;
    n = 0;
    while (int_en && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp_clks(r, 1), {tag, " R3 R4 integrate length"}, n, exp_clks(r, 1));
    n = 0;
    while (dint_en && n < 5000) begin
      if (mode == 0) zc = (n == off);
      else if (mode == 2) zc = (n == off) || (n == off2);
      n++;
      @(negedge clk);
    end
    zc = 1'b0;
    chk(n == exp_clks(r, 2), {tag, " R2 R3 de-integrate length"}, n, exp_clks(r, 2));
    n = 1;
    while (!eoc && zi_en && n < 5000) begin @(negedge clk); n++; end
    chk(n == exp_clks(r, 3) && eoc && zi_en, {tag, " R3 R8 zero-integrate length with eoc"},
        n, exp_clks(r, 3));
    chk(int'(result) == exp_res, {tag, " R5 R7 result"}, int'(result), exp_res);
    chk(ovr == exp_ovr, {tag, " R7 overrange"}, int'(ovr), int'(exp_ovr));
    rate_sel = nxt;
    @(negedge clk);
    chk(!eoc && az_en, {tag, " R8 R2 eoc single and back to auto-zero"},
        int'({eoc, az_en}), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    rst_n    = 1'b0;
    rate_sel = 2'b00;
    zc       = 1'b0;
    repeat (3) @(negedge clk);
    chk(az_en && !int_en && !dint_en && !zi_en, "R9 R1 reset phase",
        int'({az_en, int_en, dint_en, zi_en}), 8);
    chk(result == '0 && !ovr && !eoc, "R9 reset outputs", int'(result), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] nx;
      nx = (k + 1 < NVEC) ? VEC[k + 1][1:0] : 2'b00;
      run_conv(VEC[k][1:0], nx, 0, int'(VEC[k][11:2]), -1,
               int'(VEC[k][23:12]), VEC[k][24], $sformatf("vec%0d", k));
    end

    // R6: second edge ignored
    run_conv(2'b00, 2'b00, 2, 5, 20, 5, 1'b0, "second edge R6");
    // R6 R7: input already high at de-integration start gives no capture
    run_conv(2'b00, 2'b00, 1, 0, 0, 88, 1'b1, "pre-high R6");

    // R9: asynchronous reset in mid de-integration
    rate_sel = 2'b11;
    while (!dint_en) @(negedge clk);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(az_en && !dint_en && result == '0 && !ovr, "R9 mid-run reset",
        int'({az_en, dint_en, ovr}), 4);
    @(negedge clk);
    rst_n = 1'b1;
    // rate_sel is 2'b11 but the latched code restarts at 2'b00 (R9, R4)
    run_conv(2'b00, 2'b00, 0, 3, -1, 3, 1'b0, "after reset R9");

    chk(onehot_err == 0, "R1 one phase enable", onehot_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule